// File: doc/BRIEF.md
# Serial Receiver with Overrun Lockout

This block receives asynchronous serial bytes framed as one start bit, eight data bits and one stop bit. The line is oversampled with a 16x tick supplied from outside. Each finished byte moves from the shift register into a single holding register, and a ready flag goes high. The consumer pulses a read strobe to take the byte. The framing result travels with the byte, so it always describes the byte currently held.

A control/status byte holds a continuous-receive enable and two read-only flags, overrun and framing error. An overrun happens when a byte finishes while the holding register still holds an unread byte. The overrun flag then locks the receiver: later bytes are discarded and the ready flag stays low. Writing the flag has no effect. The only way to release the lock is to clear the enable and then set it again. While the enable is low, the receiver stays idle and accepts nothing.

Top module: `uart_rx_lock`

## Requirements
- R1: After reset, rx_ready is 0 and rx_stat reads 0x00. The continuous-receive enable is off.
- R2: A frame is found when the line goes low and is still low 8 ticks later. A low pulse that has returned high by then is ignored. The eight data bits are sampled every 16 ticks after that, LSB first, and the stop bit 16 ticks after the last data bit.
- R3: A transfer into the holding register sets rx_ready and puts the byte on rx_data. A one-cycle rd_stb clears rx_ready. A read in the same cycle as a byte finishing counts as in time.
- R4: rx_stat bit 2 (framing error) is 1 when the stop bit samples low. It is stored with its byte and replaced on every transfer.
- R5: rx_stat bit 1 (overrun) goes to 1 when a byte finishes while rx_ready is 1 and the byte is not being read.
- R6: While overrun is 1, rx_data does not change and rx_ready never rises again, even after the held byte has been read.
- R7: Writes to rx_stat bits 1 and 2 are ignored. A write that keeps bit 4 at 1 does not clear overrun.
- R8: A write with bit 4 = 0 clears the enable and overrun and returns the receiver to idle. No byte is received until bit 4 is written to 1 again.
- R9: The rx_stat layout is: bit 4 = enable, bit 2 = framing error, bit 1 = overrun. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Serial input line, idle high |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rd_stb | input | 1 | Reads the holding register |
| cfg_we | input | 1 | Write strobe for the control byte |
| cfg_wdata | input | 8 | Control byte write data (bit 4 = enable) |
| rx_data | output | 8 | Holding register contents |
| rx_ready | output | 1 | Holding register holds an unread byte |
| rx_stat | output | 8 | Control/status byte |

## Verification
Several byte values are sent and read promptly: alternating bits, all zeros, all ones, and a mixed value. Together they confirm the LSB-first order and show that no data bit is stuck. A frame with its stop bit held low is followed by a good frame, which shows that the framing bit follows the byte and is not sticky. A short low pulse on the line checks start qualification. Two unread bytes in a row, followed by a read, a third byte and an enable toggle, separate four cases: overrun setting, the lockout holding after a read, the flag being immune to writes, and the toggle being the only release.

// File: rtl/uart_rx_lock.sv
module uart_rx_lock #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              tick16,
  input  logic              rd_stb,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic [7:0]        rx_stat
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam int EN_BIT = 4, FE_BIT = 2, OV_BIT = 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t               st_q;
  logic [1:0]        sync_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] shf_q, hold_q;
  logic              en_q, ovr_q, fe_q, rdy_q;

  wire rx_s   = sync_q[1];
  wire dis_wr = cfg_we && !cfg_wdata[EN_BIT];
  wire fin    = tick16 && (st_q == S_STOP) && (cnt_q == LAST);
  wire room   = !rdy_q || rd_stb;
  wire load   = fin && !ovr_q && room;
  wire over   = fin && !ovr_q && !room;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      shf_q <= '0;
    end else if (!en_q || dis_wr) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
    end else if (tick16) begin
      case (st_q)
        S_IDLE:
          if (!rx_s) begin
            st_q  <= S_START;
            cnt_q <= '0;
          end
        S_START:
          if (cnt_q == MID) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= rx_s ? S_IDLE : S_DATA;
          end else cnt_q <= cnt_q + 1'b1;
        S_DATA:
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            shf_q <= {rx_s, shf_q[DATA_W-1:1]};
            if (bit_q == BW'(DATA_W - 1)) st_q <= S_STOP;
            else                          bit_q <= bit_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        default:
          if (cnt_q == LAST) st_q <= S_IDLE;
          else               cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ovr_q  <= 1'b0;
      fe_q   <= 1'b0;
      rdy_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (cfg_we) en_q <= cfg_wdata[EN_BIT];
      if (!en_q || dis_wr) ovr_q <= 1'b0;
      else if (over)       ovr_q <= 1'b1;
      if (load) begin
        hold_q <= shf_q;
        fe_q   <= !rx_s;
        rdy_q  <= 1'b1;
      end else if (rd_stb) rdy_q <= 1'b0;
    end
  end

  assign rx_data  = hold_q;
  assign rx_ready = rdy_q;

  always_comb begin
    rx_stat         = '0;
    rx_stat[EN_BIT] = en_q;
    rx_stat[FE_BIT] = fe_q;
    rx_stat[OV_BIT] = ovr_q;
  end
endmodule

module uart_rx_lock_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic              dis_wr,
  input logic              load,
  input logic              over,
  input logic              ovr,
  input logic              en,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data
);
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !dis_wr |=> ovr); // R7
  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> !ovr && !en); // R8
  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    over |=> ovr); // R5
  AST_LOCK_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> !$rose(rx_ready)); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(rx_data)); // R6
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !load |=> !rx_ready); // R3
  AST_READY_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(load)); // R3
endmodule

bind uart_rx_lock uart_rx_lock_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .dis_wr(dis_wr),
  .load(load), .over(over), .ovr(ovr_q), .en(en_q),
  .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/uart_rx_lock_tb.sv
`timescale 1ns/1ps
module uart_rx_lock_tb;
  localparam int TICK_DIV = 4;
  localparam int BITC = 16 * TICK_DIV;

  logic clk = 0, rst_n = 0, rx_in = 1, tick16 = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_wdata = 0;
  logic auto_pulse = 0, man_pulse = 0, auto_rd = 0;
  logic [7:0] rx_data, rx_stat;
  logic rx_ready;
  wire rd_stb = auto_pulse | man_pulse;

  int total = 0, bad = 0, tcnt = 0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tcnt   <= (tcnt == TICK_DIV-1) ? 0 : tcnt + 1;
    tick16 <= (tcnt == TICK_DIV-1);
  end

  uart_rx_lock u_dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16), .rd_stb(rd_stb),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_stat(rx_stat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit stop_hi, input bit expect_it);
    if (expect_it) exp_q.push_back({~stop_hi, b});
    @(negedge clk);
    rx_in = 0; clks(BITC);
    for (int i = 0; i < 8; i++) begin rx_in = b[i]; clks(BITC); end
    rx_in = stop_hi; clks(BITC);
    rx_in = 1; clks(BITC);
  endtask

  always @(negedge clk) begin
    if (auto_pulse) auto_pulse = 0;
    else if (auto_rd && rx_ready) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected byte act=%h exp=none", rx_data);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if ({rx_stat[2], rx_data} !== e) begin
          bad++;
          $display("FAIL R2/R4 act=%h exp=%h", {rx_stat[2], rx_data}, e);
        end
      end
      auto_pulse = 1;
    end
  end

  initial begin
    #(150000 * 5);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clks(4); rst_n = 1; clks(2);
    check("R1 ready", rx_ready, 0);
    check("R1 stat", rx_stat, 8'h00);
    send(8'h5A, 1, 0); clks(4);
    check("R8 disabled no rx", rx_ready, 0);

    wr_cfg(8'h16);
    check("R7/R9 stat after write", rx_stat, 8'h10);

    auto_rd = 1;
    send(8'h55, 1, 1);
    send(8'hA3, 1, 1);
    send(8'h00, 1, 1);
    send(8'hFF, 1, 1);
    send(8'h3C, 0, 1);
    send(8'hC1, 1, 1);
    clks(4);
    check("R3 all read", exp_q.size(), 0);

    @(negedge clk); rx_in = 0; clks(3 * TICK_DIV); rx_in = 1; clks(3 * BITC);
    check("R2 glitch ignored", rx_ready, 0);

    auto_rd = 0;
    send(8'h11, 1, 0); clks(4);
    check("R3 ready set", rx_ready, 1);
    check("R3 data", rx_data, 8'h11);
    send(8'h22, 0, 0); clks(4);
    check("R5 overrun set", rx_stat, 8'h12);
    check("R6 data held", rx_data, 8'h11);
    wr_cfg(8'h10);
    check("R7 overrun sticky", rx_stat[1], 1);
    @(negedge clk); man_pulse = 1; @(negedge clk); man_pulse = 0;
    check("R3 read clears", rx_ready, 0);
    send(8'h33, 1, 0); clks(4);
    check("R6 no ready in lock", rx_ready, 0);
    check("R6 data unchanged", rx_data, 8'h11);
    check("R6 overrun kept", rx_stat[1], 1);
    wr_cfg(8'h00);
    check("R8 overrun cleared", rx_stat, 8'h00);
    send(8'h44, 1, 0); clks(4);
    check("R8 no rx while off", rx_ready, 0);
    wr_cfg(8'h10);
    auto_rd = 1;
    send(8'h96, 1, 1);
    clks(4);
    check("R8 resumed", exp_q.size(), 0);
    check("R9 final stat", rx_stat, 8'h10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule